// File: doc/BRIEF.md
# Trap Return Status Update Unit

This unit computes and commits the architectural state change made by the three trap-return operations of a processor core: a return from a supervisor trap, a return from a machine trap, and a return from a non-maskable interrupt. When the core presents a return, the unit receives the current privilege level, the virtualization flag, the status, hypervisor-status and NMI-status words, the virtual-supervisor double-trap bit, the expected-landing-pad flag and the low bits of the three saved exception PCs. It produces the new privilege and virtualization mode, the updated register words, a selector that tells the fetch logic which saved PC to resume from, a one-cycle request to swap the hypervisor register banks, and an exception outcome.

The return either faults or commits, never both. A faulting return reports its cause and leaves every state output as it was. A committing return restores the interrupt-enable stack, picks the target mode, clears the memory-privilege-modify bit where required, clears the double-trap bits that apply, and restores the landing-pad flag when forward control-flow protection is on in the target mode. Each result appears one clock after the return strobe.

The status word uses this bit layout: 0 SIE, 1 MIE, 2 SPIE, 3 MPIE, 4 SPP, 6:5 MPP, 7 MPRV, 8 TSR (trap supervisor return), 9 MPV, 10 SDT (supervisor double trap), 11 MDT (machine double trap), 12 SPELP, 13 MPELP, 15:14 reserved and passed through. Hypervisor status: 0 SPV, 1 VTSR. NMI status: 0 NMIE, 1 MNPV, 2 MNPELP, 4:3 MNPP. Privilege encodings are U=0, S=1, M=3. Return kinds are 0 supervisor, 1 machine, 2 NMI. Exception codes are 0 none, 1 illegal instruction, 2 virtual instruction, 3 fetch address misaligned, 4 fetch access fault.

Top module: `trapret_top`

## Requirements
- R1: A supervisor return faults with code 1 when privilege is below S. Otherwise, after the R2 check, it faults with code 1 when TSR is set and privilege is not M. Otherwise it faults with code 2 when virtualized with VTSR set.
- R2: After the privilege check, any return faults with code 3 when cfg_has_c is 0 and the two low bits of the selected saved PC are not 00.
- R3: Machine and NMI returns fault with code 1 when privilege is not M. After R2, they fault with code 4 when cfg_prot_en and cfg_prot_none are both 1 and the target privilege is not M. Return kind 3 always faults with code 1.
- R4: A faulting return leaves every state output unchanged and does not pulse swap_o.
- R5: A supervisor return sets the privilege to SPP. It copies SPIE into SIE, sets SPIE to 1, clears SPP and clears MPRV.
- R6: With cfg_has_h set and virtualization off, a supervisor return takes the new virtualization from SPV, clears SPV, and pulses swap_o when SPV was 1. Otherwise virtualization is unchanged and swap_o stays low.
- R7: A machine return copies MPIE into MIE and sets MPIE to 1. It sets MPP to U when cfg_has_u is 1 and to M otherwise, and clears MPV. The new privilege is the old MPP. The new virtualization is MPV AND (MPP != M), and swap_o pulses when that value is 1 and cfg_has_h is 1.
- R8: A machine return clears MPRV only when the target is not M. An NMI return sets NMIE, keeps MNPP and MNPV, clears MPRV only when the target is below M, and takes privilege MNPP and virtualization MNPV AND (MNPP != M).
- R9: With cfg_dbl_s set, a supervisor return clears SDT. It also clears vs_sdt_o when the hypervisor is present, virtualization is off, SPV is 1 and SPP is U. Machine and NMI returns clear SDT when the target is U, or virtualized S or U. They clear vs_sdt_o when the target is virtualized U.
- R10: With cfg_dbl_m set, a machine return always clears MDT. An NMI return clears MDT only when the target is below M. A supervisor return clears MDT only when executed in M.
- R11: When bit [new privilege] of the landing-pad enable mask is 1, elp_o takes the saved landing-pad bit of the return kind (SPELP, MPELP or MNPELP). Otherwise elp_o keeps elp_i. That saved bit is cleared on every committed return.
- R12: done_o pulses exactly one cycle after each ret_valid cycle. In that cycle exc_o carries the outcome, and pc_sel_o equals the return kind (0 supervisor, 1 machine, 2 NMI).
- R13: After reset, privilege is M, virtualization is 0, all register-word outputs, elp_o and vs_sdt_o are 0, and done_o, swap_o and exc_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | Return strobe, one cycle per return |
| ret_kind | input | 2 | 0 supervisor, 1 machine, 2 NMI |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current virtualization flag |
| status_i | input | 16 | Status word |
| hstat_i | input | 2 | Hypervisor status word |
| nmstat_i | input | 5 | NMI status word |
| vs_sdt_i | input | 1 | Virtual-supervisor double-trap bit |
| elp_i | input | 1 | Current expected-landing-pad flag |
| pclo_s_i | input | 2 | Low bits of saved supervisor PC |
| pclo_m_i | input | 2 | Low bits of saved machine PC |
| pclo_n_i | input | 2 | Low bits of saved NMI PC |
| cfg_has_u | input | 1 | User mode present |
| cfg_has_h | input | 1 | Hypervisor present |
| cfg_has_c | input | 1 | Compressed instructions supported |
| cfg_dbl_s | input | 1 | Supervisor double-trap support |
| cfg_dbl_m | input | 1 | Machine double-trap support |
| cfg_prot_en | input | 1 | Physical memory protection present |
| cfg_prot_none | input | 1 | No protection rules configured |
| cfg_lp_en | input | 4 | Landing-pad enable, one bit per privilege encoding |
| done_o | output | 1 | Result valid pulse |
| exc_o | output | 3 | Exception code |
| pc_sel_o | output | 2 | Saved PC to resume from |
| status_o | output | 16 | Updated status word |
| hstat_o | output | 2 | Updated hypervisor status word |
| nmstat_o | output | 5 | Updated NMI status word |
| vs_sdt_o | output | 1 | Updated virtual-supervisor double-trap bit |
| elp_o | output | 1 | Updated expected-landing-pad flag |
| priv_o | output | 2 | New privilege |
| virt_o | output | 1 | New virtualization flag |
| swap_o | output | 1 | Hypervisor register-bank swap pulse |

## Verification
On every cycle, the assertions check the return timing: done follows each strobe and swap occurs only on a committed return. They also check the privilege faults of both return families, the freeze of state after any fault, the fixed supervisor field updates, NMIE being set, and MPRV surviving a machine return to M. The priority among fault causes, the exact masks of the double-trap clears, the virtualization restore with and without a hypervisor, and the landing-pad restore per target mode can only be shown by the bench. The bench does this with its table of return scenarios and with directed sequences that commit one return and then fault the next.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

    localparam int ST_W  = 16;
    localparam int HS_W  = 2;
    localparam int NM_W  = 5;
    localparam int PRV_W = 2;
    localparam int EXC_W = 3;
    localparam int LP_N  = 1 << PRV_W;

    // status word bit positions
    localparam int ST_SIE   = 0;
    localparam int ST_MIE   = 1;
    localparam int ST_SPIE  = 2;
    localparam int ST_MPIE  = 3;
    localparam int ST_SPP   = 4;
    localparam int ST_MPP_L = 5;
    localparam int ST_MPP_H = 6;
    localparam int ST_MPRV  = 7;
    localparam int ST_TSR   = 8;
    localparam int ST_MPV   = 9;
    localparam int ST_SDT   = 10;
    localparam int ST_MDT   = 11;
    localparam int ST_SPELP = 12;
    localparam int ST_MPELP = 13;

    // hypervisor status bit positions
    localparam int HS_SPV  = 0;
    localparam int HS_VTSR = 1;

    // NMI status bit positions
    localparam int NM_NMIE  = 0;
    localparam int NM_MNPV  = 1;
    localparam int NM_LPE   = 2;
    localparam int NM_PP_L  = 3;
    localparam int NM_PP_H  = 4;

    localparam logic [PRV_W-1:0] PRV_U = 2'd0;
    localparam logic [PRV_W-1:0] PRV_S = 2'd1;
    localparam logic [PRV_W-1:0] PRV_M = 2'd3;

    typedef enum logic [1:0] {
        RET_SUP = 2'd0,
        RET_MAC = 2'd1,
        RET_NMI = 2'd2,
        RET_BAD = 2'd3
    } ret_kind_e;

    typedef enum logic [EXC_W-1:0] {
        EXC_NONE  = 3'd0,
        EXC_ILL   = 3'd1,
        EXC_VIRT  = 3'd2,
        EXC_MISAL = 3'd3,
        EXC_ACCF  = 3'd4
    } exc_e;

    typedef struct packed {
        logic [ST_W-1:0]  st;
        logic [HS_W-1:0]  hs;
        logic [NM_W-1:0]  nm;
        logic             vsd;
        logic             elp;
        logic [PRV_W-1:0] priv;
        logic             virt;
        logic             swap;
    } ret_state_t;

    function automatic logic [PRV_W-1:0] ret_target(
        input ret_kind_e        kind,
        input logic             spp,
        input logic [PRV_W-1:0] mpp,
        input logic [PRV_W-1:0] mnpp
    );
        case (kind)
            RET_SUP: ret_target = {1'b0, spp};
            RET_MAC: ret_target = mpp;
            RET_NMI: ret_target = mnpp;
            default: ret_target = PRV_M;
        endcase
    endfunction

endpackage

// File: rtl/trapret_check.sv
module trapret_check
    import trapret_pkg::*;
(
    input  ret_kind_e        kind,
    input  logic [PRV_W-1:0] cur_priv,
    input  logic             cur_virt,
    input  logic [PRV_W-1:0] tgt_priv,
    input  logic             tsr,
    input  logic             vtsr,
    input  logic [1:0]       pc_lo,
    input  logic             has_c,
    input  logic             prot_en,
    input  logic             prot_none,
    output exc_e             exc
);

    logic misal;

    assign misal = !has_c && (pc_lo != 2'b00);

    always_comb begin
        exc = EXC_NONE;
        case (kind)
            RET_SUP: begin
                if (cur_priv < PRV_S)                     exc = EXC_ILL;
                else if (misal)                           exc = EXC_MISAL;
                else if (tsr && cur_priv != PRV_M)        exc = EXC_ILL;
                else if (cur_virt && vtsr)                exc = EXC_VIRT;
            end
            RET_MAC, RET_NMI: begin
                if (cur_priv != PRV_M)                    exc = EXC_ILL;
                else if (misal)                           exc = EXC_MISAL;
                else if (prot_en && prot_none && tgt_priv != PRV_M)
                                                          exc = EXC_ACCF;
            end
            default:                                      exc = EXC_ILL;
        endcase
    end

endmodule

// File: rtl/trapret_next.sv
module trapret_next
    import trapret_pkg::*;
(
    input  ret_kind_e        kind,
    input  logic [PRV_W-1:0] cur_priv,
    input  logic             cur_virt,
    input  logic [PRV_W-1:0] tgt_priv,
    input  logic [ST_W-1:0]  st_i,
    input  logic [HS_W-1:0]  hs_i,
    input  logic [NM_W-1:0]  nm_i,
    input  logic             vsd_i,
    input  logic             elp_i,
    input  logic             has_u,
    input  logic             has_h,
    input  logic             dbl_s,
    input  logic             dbl_m,
    input  logic [LP_N-1:0]  lp_en,
    output ret_state_t       nx
);

    logic tv;
    logic saved_lp;
    logic to_lower;

    assign to_lower = (tgt_priv != PRV_M);

    always_comb begin
        nx       = '0;
        nx.st    = st_i;
        nx.hs    = hs_i;
        nx.nm    = nm_i;
        nx.vsd   = vsd_i;
        nx.elp   = elp_i;
        nx.swap  = 1'b0;
        tv       = cur_virt;
        saved_lp = elp_i;

        case (kind)
            RET_SUP: begin
                nx.st[ST_SIE]  = st_i[ST_SPIE];
                nx.st[ST_SPIE] = 1'b1;
                nx.st[ST_SPP]  = 1'b0;
                nx.st[ST_MPRV] = 1'b0;
                if (dbl_s) begin
                    if (has_h && !cur_virt && hs_i[HS_SPV] && tgt_priv == PRV_U)
                        nx.vsd = 1'b0;
                    nx.st[ST_SDT] = 1'b0;
                end
                if (dbl_m && cur_priv == PRV_M)
                    nx.st[ST_MDT] = 1'b0;
                if (has_h && !cur_virt) begin
                    tv            = hs_i[HS_SPV];
                    nx.hs[HS_SPV] = 1'b0;
                    nx.swap       = hs_i[HS_SPV];
                end
                saved_lp        = st_i[ST_SPELP];
                nx.st[ST_SPELP] = 1'b0;
            end
            RET_MAC: begin
                tv = st_i[ST_MPV] && to_lower;
                nx.st[ST_MIE]             = st_i[ST_MPIE];
                nx.st[ST_MPIE]            = 1'b1;
                nx.st[ST_MPP_H:ST_MPP_L]  = has_u ? PRV_U : PRV_M;
                nx.st[ST_MPV]             = 1'b0;
                if (dbl_m)
                    nx.st[ST_MDT] = 1'b0;
                if (to_lower)
                    nx.st[ST_MPRV] = 1'b0;
                nx.swap         = has_h && tv;
                saved_lp        = st_i[ST_MPELP];
                nx.st[ST_MPELP] = 1'b0;
            end
            RET_NMI: begin
                tv = nm_i[NM_MNPV] && to_lower;
                nx.nm[NM_NMIE] = 1'b1;
                if (to_lower)
                    nx.st[ST_MPRV] = 1'b0;
                if (dbl_m && to_lower)
                    nx.st[ST_MDT] = 1'b0;
                nx.swap        = has_h && tv;
                saved_lp       = nm_i[NM_LPE];
                nx.nm[NM_LPE]  = 1'b0;
            end
            default: ;
        endcase

        // shared supervisor double-trap rule for the two machine-level returns
        if (dbl_s && (kind == RET_MAC || kind == RET_NMI)) begin
            if (tgt_priv == PRV_U || (tv && (tgt_priv == PRV_S || tgt_priv == PRV_U)))
                nx.st[ST_SDT] = 1'b0;
            if (tv && tgt_priv == PRV_U)
                nx.vsd = 1'b0;
        end

        nx.priv = tgt_priv;
        nx.virt = tv;
        if (lp_en[tgt_priv])
            nx.elp = saved_lp;
    end

endmodule

// File: rtl/trapret_top.sv
module trapret_top
    import trapret_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ret_valid,
    input  logic [1:0]           ret_kind,
    input  logic [PRV_W-1:0]     cur_priv,
    input  logic                 cur_virt,
    input  logic [ST_W-1:0]      status_i,
    input  logic [HS_W-1:0]      hstat_i,
    input  logic [NM_W-1:0]      nmstat_i,
    input  logic                 vs_sdt_i,
    input  logic                 elp_i,
    input  logic [1:0]           pclo_s_i,
    input  logic [1:0]           pclo_m_i,
    input  logic [1:0]           pclo_n_i,
    input  logic                 cfg_has_u,
    input  logic                 cfg_has_h,
    input  logic                 cfg_has_c,
    input  logic                 cfg_dbl_s,
    input  logic                 cfg_dbl_m,
    input  logic                 cfg_prot_en,
    input  logic                 cfg_prot_none,
    input  logic [LP_N-1:0]      cfg_lp_en,
    output logic                 done_o,
    output logic [EXC_W-1:0]     exc_o,
    output logic [1:0]           pc_sel_o,
    output logic [ST_W-1:0]      status_o,
    output logic [HS_W-1:0]      hstat_o,
    output logic [NM_W-1:0]      nmstat_o,
    output logic                 vs_sdt_o,
    output logic                 elp_o,
    output logic [PRV_W-1:0]     priv_o,
    output logic                 virt_o,
    output logic                 swap_o
);

    ret_kind_e        kind;
    logic [PRV_W-1:0] tgt;
    logic [1:0]       pc_lo;
    exc_e             exc_c;
    ret_state_t       nx;
    ret_state_t       st_q;
    logic             done_q;
    exc_e             exc_q;
    logic [1:0]       sel_q;

    assign kind = ret_kind_e'(ret_kind);
    assign tgt  = ret_target(kind, status_i[ST_SPP],
                             status_i[ST_MPP_H:ST_MPP_L],
                             nmstat_i[NM_PP_H:NM_PP_L]);

    always_comb begin
        case (kind)
            RET_SUP: pc_lo = pclo_s_i;
            RET_MAC: pc_lo = pclo_m_i;
            RET_NMI: pc_lo = pclo_n_i;
            default: pc_lo = 2'b00;
        endcase
    end

    trapret_check u_check (
        .kind      (kind),
        .cur_priv  (cur_priv),
        .cur_virt  (cur_virt),
        .tgt_priv  (tgt),
        .tsr       (status_i[ST_TSR]),
        .vtsr      (hstat_i[HS_VTSR]),
        .pc_lo     (pc_lo),
        .has_c     (cfg_has_c),
        .prot_en   (cfg_prot_en),
        .prot_none (cfg_prot_none),
        .exc       (exc_c)
    );

    trapret_next u_next (
        .kind     (kind),
        .cur_priv (cur_priv),
        .cur_virt (cur_virt),
        .tgt_priv (tgt),
        .st_i     (status_i),
        .hs_i     (hstat_i),
        .nm_i     (nmstat_i),
        .vsd_i    (vs_sdt_i),
        .elp_i    (elp_i),
        .has_u    (cfg_has_u),
        .has_h    (cfg_has_h),
        .dbl_s    (cfg_dbl_s),
        .dbl_m    (cfg_dbl_m),
        .lp_en    (cfg_lp_en),
        .nx       (nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q       <= 1'b0;
            exc_q        <= EXC_NONE;
            sel_q        <= 2'd0;
            st_q         <= '0;
            st_q.priv    <= PRV_M;
        end else begin
            done_q    <= ret_valid;
            exc_q     <= ret_valid ? exc_c : EXC_NONE;
            st_q.swap <= 1'b0;
            if (ret_valid) begin
                sel_q <= ret_kind;
                if (exc_c == EXC_NONE)
                    st_q <= nx;
            end
        end
    end

    assign done_o   = done_q;
    assign exc_o    = exc_q;
    assign pc_sel_o = sel_q;
    assign status_o = st_q.st;
    assign hstat_o  = st_q.hs;
    assign nmstat_o = st_q.nm;
    assign vs_sdt_o = st_q.vsd;
    assign elp_o    = st_q.elp;
    assign priv_o   = st_q.priv;
    assign virt_o   = st_q.virt;
    assign swap_o   = st_q.swap;

    AST_SRET_LOW_PRIV: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && kind == RET_SUP && cur_priv < PRV_S) |=> (exc_q == EXC_ILL)); // R1

    AST_MRET_LOW_PRIV: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && (kind == RET_MAC || kind == RET_NMI) && cur_priv != PRV_M)
        |=> (exc_q == EXC_ILL)); // R3

    AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && exc_c != EXC_NONE)
        |=> ($stable(status_o) && $stable(priv_o) && $stable(virt_o) && !swap_o)); // R4

    AST_SRET_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (done_q && exc_q == EXC_NONE && sel_q == RET_SUP)
        |-> (status_o[ST_SPIE] && !status_o[ST_SPP] && !status_o[ST_MPRV])); // R5

    AST_SWAP_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        swap_o |-> (done_q && exc_q == EXC_NONE)); // R6

    AST_MPRV_KEPT_TO_M: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && kind == RET_MAC && exc_c == EXC_NONE
         && status_i[ST_MPP_H:ST_MPP_L] == PRV_M)
        |=> (status_o[ST_MPRV] == $past(status_i[ST_MPRV]))); // R8

    AST_NMIE_SET: assert property (@(posedge clk) disable iff (rst)
        (done_q && exc_q == EXC_NONE && sel_q == RET_NMI) |-> nmstat_o[NM_NMIE]); // R8

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> done_o); // R12

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ret_valid |=> !done_o); // R12

endmodule

// File: tb/tb_trapret_top.sv
module tb_trapret_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_kind = 2'd0;
    logic [1:0]  cur_priv = 2'd3;
    logic        cur_virt = 1'b0;
    logic [15:0] status_i = '0;
    logic [1:0]  hstat_i = '0;
    logic [4:0]  nmstat_i = '0;
    logic        vs_sdt_i = 1'b1;
    logic        elp_i = 1'b0;
    logic [1:0]  pclo = 2'b00;
    logic [7:0]  cfg = 8'hE0;
    logic        done_o, vs_sdt_o, elp_o, virt_o, swap_o;
    logic [2:0]  exc_o;
    logic [1:0]  pc_sel_o, priv_o, hstat_o;
    logic [15:0] status_o;
    logic [4:0]  nmstat_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    trapret_top dut (
        .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_kind(ret_kind),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .status_i(status_i),
        .hstat_i(hstat_i), .nmstat_i(nmstat_i), .vs_sdt_i(vs_sdt_i), .elp_i(elp_i),
        .pclo_s_i(pclo), .pclo_m_i(pclo), .pclo_n_i(pclo),
        .cfg_has_u(cfg[7]), .cfg_has_h(cfg[6]), .cfg_has_c(cfg[5]),
        .cfg_dbl_s(cfg[4]), .cfg_dbl_m(cfg[3]), .cfg_prot_en(cfg[2]),
        .cfg_prot_none(cfg[1]), .cfg_lp_en({4{cfg[0]}}),
        .done_o(done_o), .exc_o(exc_o), .pc_sel_o(pc_sel_o), .status_o(status_o),
        .hstat_o(hstat_o), .nmstat_o(nmstat_o), .vs_sdt_o(vs_sdt_o), .elp_o(elp_o),
        .priv_o(priv_o), .virt_o(virt_o), .swap_o(swap_o)
    );

    // cfg bits: {has_u, has_h, has_c, dbl_s, dbl_m, prot_en, prot_none, lp_en_all}
    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  kind;
        logic [1:0]  priv;
        logic        virt;
        logic [15:0] st;
        logic [1:0]  hs;
        logic [4:0]  nm;
        logic [1:0]  pc;
        logic [7:0]  cf;
        logic [2:0]  e_exc;
        logic [1:0]  e_priv;
        logic        e_virt;
        logic [15:0] e_st;
        logic        e_swap;
        logic        e_vsd;
        logic        e_elp;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{4'd5,  2'd0, 2'd1, 1'b0, 16'h0094, 2'b00, 5'h00, 2'b00, 8'hE0, 3'd0, 2'd1, 1'b0, 16'h0005, 1'b0, 1'b1, 1'b0}, // R5
        '{4'd6,  2'd0, 2'd1, 1'b0, 16'h0000, 2'b01, 5'h00, 2'b00, 8'hE0, 3'd0, 2'd0, 1'b1, 16'h0004, 1'b1, 1'b1, 1'b0}, // R6
        '{4'd1,  2'd0, 2'd0, 1'b0, 16'h0000, 2'b00, 5'h00, 2'b00, 8'hE0, 3'd1, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R1
        '{4'd1,  2'd0, 2'd1, 1'b0, 16'h0100, 2'b00, 5'h00, 2'b00, 8'hE0, 3'd1, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R1
        '{4'd1,  2'd0, 2'd3, 1'b0, 16'h0110, 2'b00, 5'h00, 2'b00, 8'hE0, 3'd0, 2'd1, 1'b0, 16'h0104, 1'b0, 1'b1, 1'b0}, // R1
        '{4'd1,  2'd0, 2'd1, 1'b1, 16'h0000, 2'b10, 5'h00, 2'b00, 8'hE0, 3'd2, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R1
        '{4'd2,  2'd0, 2'd1, 1'b0, 16'h0000, 2'b00, 5'h00, 2'b10, 8'hC0, 3'd3, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R2
        '{4'd2,  2'd0, 2'd1, 1'b0, 16'h0000, 2'b00, 5'h00, 2'b10, 8'hE0, 3'd0, 2'd0, 1'b0, 16'h0004, 1'b0, 1'b1, 1'b0}, // R2
        '{4'd6,  2'd0, 2'd1, 1'b0, 16'h0000, 2'b01, 5'h00, 2'b00, 8'hA0, 3'd0, 2'd0, 1'b0, 16'h0004, 1'b0, 1'b1, 1'b0}, // R6
        '{4'd7,  2'd1, 2'd3, 1'b0, 16'h00A8, 2'b00, 5'h00, 2'b00, 8'hE0, 3'd0, 2'd1, 1'b0, 16'h000A, 1'b0, 1'b1, 1'b0}, // R7
        '{4'd8,  2'd1, 2'd3, 1'b0, 16'h00E0, 2'b00, 5'h00, 2'b00, 8'h60, 3'd0, 2'd3, 1'b0, 16'h00E8, 1'b0, 1'b1, 1'b0}, // R8
        '{4'd7,  2'd1, 2'd3, 1'b0, 16'h0200, 2'b00, 5'h00, 2'b00, 8'hE0, 3'd0, 2'd0, 1'b1, 16'h0008, 1'b1, 1'b1, 1'b0}, // R7
        '{4'd7,  2'd1, 2'd3, 1'b0, 16'h0260, 2'b00, 5'h00, 2'b00, 8'hE0, 3'd0, 2'd3, 1'b0, 16'h0008, 1'b0, 1'b1, 1'b0}, // R7
        '{4'd3,  2'd1, 2'd1, 1'b0, 16'h0000, 2'b00, 5'h00, 2'b00, 8'hE0, 3'd1, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R3
        '{4'd3,  2'd1, 2'd3, 1'b0, 16'h0020, 2'b00, 5'h00, 2'b00, 8'hE6, 3'd4, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R3
        '{4'd3,  2'd1, 2'd3, 1'b0, 16'h0060, 2'b00, 5'h00, 2'b00, 8'hE6, 3'd0, 2'd3, 1'b0, 16'h0008, 1'b0, 1'b1, 1'b0}, // R3
        '{4'd8,  2'd2, 2'd3, 1'b0, 16'h0080, 2'b00, 5'h08, 2'b00, 8'hE0, 3'd0, 2'd1, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0}, // R8
        '{4'd8,  2'd2, 2'd3, 1'b0, 16'h0080, 2'b00, 5'h18, 2'b00, 8'hE0, 3'd0, 2'd3, 1'b0, 16'h0080, 1'b0, 1'b1, 1'b0}, // R8
        '{4'd3,  2'd2, 2'd1, 1'b0, 16'h0000, 2'b00, 5'h18, 2'b00, 8'hE0, 3'd1, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R3
        '{4'd2,  2'd1, 2'd3, 1'b0, 16'h00A8, 2'b00, 5'h00, 2'b01, 8'hC0, 3'd3, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R2
        '{4'd9,  2'd0, 2'd1, 1'b0, 16'h0400, 2'b01, 5'h00, 2'b00, 8'hF0, 3'd0, 2'd0, 1'b1, 16'h0004, 1'b1, 1'b0, 1'b0}, // R9
        '{4'd9,  2'd1, 2'd3, 1'b0, 16'h0420, 2'b00, 5'h00, 2'b00, 8'hF0, 3'd0, 2'd1, 1'b0, 16'h0408, 1'b0, 1'b1, 1'b0}, // R9
        '{4'd9,  2'd1, 2'd3, 1'b0, 16'h0600, 2'b00, 5'h00, 2'b00, 8'hF0, 3'd0, 2'd0, 1'b1, 16'h0008, 1'b1, 1'b0, 1'b0}, // R9
        '{4'd10, 2'd1, 2'd3, 1'b0, 16'h0860, 2'b00, 5'h00, 2'b00, 8'hE8, 3'd0, 2'd3, 1'b0, 16'h0008, 1'b0, 1'b1, 1'b0}, // R10
        '{4'd10, 2'd0, 2'd1, 1'b0, 16'h0800, 2'b00, 5'h00, 2'b00, 8'hE8, 3'd0, 2'd0, 1'b0, 16'h0804, 1'b0, 1'b1, 1'b0}, // R10
        '{4'd10, 2'd2, 2'd3, 1'b0, 16'h0800, 2'b00, 5'h00, 2'b00, 8'hE8, 3'd0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0}, // R10
        '{4'd10, 2'd2, 2'd3, 1'b0, 16'h0800, 2'b00, 5'h18, 2'b00, 8'hE8, 3'd0, 2'd3, 1'b0, 16'h0800, 1'b0, 1'b1, 1'b0}, // R10
        '{4'd10, 2'd0, 2'd3, 1'b0, 16'h0810, 2'b00, 5'h00, 2'b00, 8'hE8, 3'd0, 2'd1, 1'b0, 16'h0004, 1'b0, 1'b1, 1'b0}, // R10
        '{4'd11, 2'd0, 2'd1, 1'b0, 16'h1000, 2'b00, 5'h00, 2'b00, 8'hE1, 3'd0, 2'd0, 1'b0, 16'h0004, 1'b0, 1'b1, 1'b1}, // R11
        '{4'd11, 2'd0, 2'd1, 1'b0, 16'h1000, 2'b00, 5'h00, 2'b00, 8'hE0, 3'd0, 2'd0, 1'b0, 16'h0004, 1'b0, 1'b1, 1'b0}, // R11
        '{4'd11, 2'd1, 2'd3, 1'b0, 16'h2060, 2'b00, 5'h00, 2'b00, 8'hE1, 3'd0, 2'd3, 1'b0, 16'h0008, 1'b0, 1'b1, 1'b1}, // R11
        '{4'd11, 2'd2, 2'd3, 1'b0, 16'h0000, 2'b00, 5'h0C, 2'b00, 8'hE1, 3'd0, 2'd1, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1}, // R11
        '{4'd3,  2'd3, 2'd3, 1'b0, 16'h0000, 2'b00, 5'h00, 2'b00, 8'hE0, 3'd1, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}  // R3
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] k, input logic [1:0] p, input logic v,
                         input logic [15:0] st, input logic [1:0] hs, input logic [4:0] nm,
                         input logic [1:0] pc, input logic [7:0] cf);
        @(negedge clk);
        ret_kind = k; cur_priv = p; cur_virt = v; status_i = st;
        hstat_i = hs; nmstat_i = nm; pclo = pc; cfg = cf; ret_valid = 1'b1;
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13", "priv", priv_o, 2'd3);
        chk("R13", "virt", virt_o, 1'b0);
        chk("R13", "status", status_o, 16'h0);
        chk("R13", "done", done_o, 1'b0);
        chk("R13", "swap", swap_o, 1'b0);
        chk("R13", "exc", exc_o, 3'd0);
        chk("R13", "vsd", vs_sdt_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rs;
            v  = VEC[i];
            rs = $sformatf("R%0d vec%0d", v.rq, i);
            apply(v.kind, v.priv, v.virt, v.st, v.hs, v.nm, v.pc, v.cf);
            chk(rs, "exc", exc_o, v.e_exc);
            if (v.e_exc == 3'd0) begin
                chk(rs, "priv", priv_o, v.e_priv);
                chk(rs, "virt", virt_o, v.e_virt);
                chk(rs, "status", status_o, v.e_st);
                chk(rs, "swap", swap_o, v.e_swap);
                chk(rs, "vsd", vs_sdt_o, v.e_vsd);
                chk(rs, "elp", elp_o, v.e_elp);
            end
        end

        // R12 timing and PC selection
        apply(2'd0, 2'd1, 1'b0, 16'h0094, 2'b00, 5'h00, 2'b00, 8'hE0);
        chk("R12", "done", done_o, 1'b1);
        chk("R12", "pc_sel sup", pc_sel_o, 2'd0);
        @(negedge clk);
        chk("R12", "done low", done_o, 1'b0);
        chk("R12", "exc idle", exc_o, 3'd0);
        apply(2'd1, 2'd3, 1'b0, 16'h0060, 2'b00, 5'h00, 2'b00, 8'hE0);
        chk("R12", "pc_sel mac", pc_sel_o, 2'd1);
        apply(2'd2, 2'd3, 1'b0, 16'h0000, 2'b00, 5'h18, 2'b00, 8'hE0);
        chk("R12", "pc_sel nmi", pc_sel_o, 2'd2);

        // R4 fault after a commit leaves state alone
        apply(2'd0, 2'd1, 1'b0, 16'h0094, 2'b00, 5'h00, 2'b00, 8'hE0);
        apply(2'd0, 2'd0, 1'b0, 16'hC3FF, 2'b01, 5'h1F, 2'b00, 8'hE0);
        chk("R4", "exc", exc_o, 3'd1);
        chk("R4", "status held", status_o, 16'h0005);
        chk("R4", "priv held", priv_o, 2'd1);
        chk("R4", "hstat held", hstat_o, 2'b00);
        chk("R4", "swap", swap_o, 1'b0);

        // R6 SPV cleared, VTSR kept when not virtualized
        apply(2'd0, 2'd1, 1'b0, 16'h0000, 2'b11, 5'h00, 2'b00, 8'hE0);
        chk("R6", "hstat", hstat_o, 2'b10);
        chk("R6", "swap pulse", swap_o, 1'b1);
        @(negedge clk);
        chk("R6", "swap one cycle", swap_o, 1'b0);

        // R8 NMI status: NMIE set, MNPP kept, saved pad bit cleared
        apply(2'd2, 2'd3, 1'b0, 16'h0000, 2'b00, 5'h0C, 2'b00, 8'hE0);
        chk("R8", "nmstat", nmstat_o, 5'h09);
        chk("R11", "nmi pad clear", nmstat_o[2], 1'b0);

        // R11 flag kept when target mode has landing pads off
        elp_i = 1'b1;
        apply(2'd0, 2'd1, 1'b0, 16'h0010, 2'b00, 5'h00, 2'b00, 8'hE0);
        chk("R11", "elp kept", elp_o, 1'b1);
        apply(2'd0, 2'd1, 1'b0, 16'h0010, 2'b00, 5'h00, 2'b00, 8'hE1);
        chk("R11", "elp restored 0", elp_o, 1'b0);
        elp_i = 1'b0;

        finish_run();
    end

endmodule